// File: doc/BRIEF.md
# Subtract-with-Borrow Arithmetic Unit

This block takes an accumulator byte and an operand byte and forms their difference, treating the incoming carry flag as an inverted borrow. When the carry is 1 there is no borrow. When it is 0, one extra unit is taken away. The carry that comes out follows the same rule: 1 means the subtraction completed without a borrow.

A decimal-mode input selects how the bytes are read. In binary mode they are plain bytes, and the unit reports sign, zero and signed-overflow flags. In decimal mode each byte is read as packed BCD digits, and the difference is corrected digit by digit. In decimal mode only the result and the carry have a defined meaning.

Wider integers are subtracted one byte at a time, starting with the least significant byte. The first byte is done with the carry set to 1. Each later byte uses the carry produced by the byte before it. The arithmetic itself is combinational. The result and all flags are captured into output registers on an enable strobe.

Top module: `sbc_unit`

## Requirements
- R1: In binary mode (`dec_mode`=0), the captured `diff` equals `acc - opnd - (1 - carry_in)`, modulo 2^W.
- R2: In binary mode, `carry_out` is 1 exactly when `acc >= opnd + (1 - carry_in)`, comparing both sides as unsigned values.
- R3: In binary mode, `negative` equals the most significant bit of `diff`.
- R4: In binary mode, `zero` is 1 exactly when every bit of `diff` is 0.
- R5: In binary mode, `overflow` is 1 exactly when the signed two's-complement difference `acc - opnd - (1 - carry_in)` falls outside the range -2^(W-1) .. 2^(W-1)-1.
- R6: In decimal mode (`dec_mode`=1), each nibble of `acc` and `opnd` holds one decimal digit 0-9, with the least significant digit in bits 3:0. The captured `diff` is the BCD encoding of `(acc - opnd - (1 - carry_in)) mod 10^NIBBLES`.
- R7: In decimal mode, `carry_out` is 1 exactly when the decimal difference is not negative. This value equals the `carry_out` that binary mode would give for the same input bits.
- R8: Subtracting a multi-byte integer byte by byte gives the correct full-width difference and final borrow for both unsigned and signed operands. The least significant byte is done first with `carry_in`=1, and each following byte takes the previous `carry_out` as its `carry_in`. The overflow flag of the top byte reports signed overflow of the whole value.
- R9: The outputs take the new values one clock edge after a cycle in which `en`=1. They keep their values on any edge where `en`=0.
- R10: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Capture strobe for the result and the flags |
| dec_mode | input | 1 | 1 selects packed-BCD arithmetic |
| carry_in | input | 1 | Incoming carry; 0 means borrow one |
| acc | input | W | Minuend (accumulator value) |
| opnd | input | W | Subtrahend (memory operand) |
| diff | output | W | Captured difference |
| carry_out | output | 1 | Captured carry; 1 means no borrow |
| zero | output | 1 | Captured zero flag (defined in binary mode only) |
| negative | output | 1 | Captured sign flag (defined in binary mode only) |
| overflow | output | 1 | Captured signed-overflow flag (defined in binary mode only) |

## Verification
The bench builds the unit with NIBBLES=2, which makes the datapath 8 bits wide. At this width every binary operand pair can be applied with both carry values, so all 131072 combinations are covered. This includes every wrap at zero and every signed overflow at the boundaries of ±128. Every valid two-digit BCD pair is also applied with both carry values. Short chained sequences of two bytes then confirm that the borrow passes correctly from one byte to the next.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef struct packed {
    logic carry;
    logic zero;
    logic neg;
    logic ovf;
  } sbc_flags_t;

  // one nibble of a + ~m + c : returns {carry, sum}
  function automatic logic [4:0] nib_sub(input logic [3:0] a, input logic [3:0] m,
                                         input logic c);
    return {1'b0, a} + {1'b0, ~m} + {4'b0000, c};
  endfunction

  // BCD digit correction: take 6 away from a digit that borrowed
  function automatic logic [3:0] digit_fix(input logic [3:0] d, input logic borrowed);
    return borrowed ? (d - 4'd6) : d;
  endfunction

endpackage

// File: rtl/sbc_bin_chain.sv
module sbc_bin_chain #(
  parameter int NIBBLES = 2,
  localparam int W = 4 * NIBBLES
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     m,
  input  logic             cin,
  output logic [W-1:0]     d,
  output logic [NIBBLES:0] nib_carry
);
  import sbc_pkg::*;

  assign nib_carry[0] = cin;

  for (genvar i = 0; i < NIBBLES; i++) begin : g_nib
    logic [4:0] s;
    assign s              = nib_sub(a[4*i +: 4], m[4*i +: 4], nib_carry[i]);
    assign d[4*i +: 4]    = s[3:0];
    assign nib_carry[i+1] = s[4];
  end
endmodule

// File: rtl/sbc_dec_adjust.sv
module sbc_dec_adjust #(
  parameter int NIBBLES = 2,
  localparam int W = 4 * NIBBLES
) (
  input  logic [W-1:0]     bin_d,
  input  logic [NIBBLES:0] nib_carry,
  output logic [W-1:0]     dec_d
);
  import sbc_pkg::*;

  for (genvar i = 0; i < NIBBLES; i++) begin : g_fix
    assign dec_d[4*i +: 4] = digit_fix(bin_d[4*i +: 4], ~nib_carry[i+1]);
  end
endmodule

// File: rtl/sbc_flag_gen.sv
module sbc_flag_gen #(
  parameter int W = 8
) (
  input  logic                a,
  input  logic                m,
  input  logic [W-1:0]        r,
  input  logic                carry,
  output sbc_pkg::sbc_flags_t flags
);
  // a, m: sign bits of the operands; r: binary result
  always_comb begin
    flags.carry = carry;
    flags.zero  = ~|r;
    flags.neg   = r[W-1];
    flags.ovf   = (a ^ m) & (a ^ r[W-1]);
  end
endmodule

// File: rtl/sbc_unit.sv
module sbc_unit #(
  parameter int NIBBLES = 2,
  localparam int W = 4 * NIBBLES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         dec_mode,
  input  logic         carry_in,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] diff,
  output logic         carry_out,
  output logic         zero,
  output logic         negative,
  output logic         overflow
);
  import sbc_pkg::*;

  logic [W-1:0]     bin_diff;
  logic [W-1:0]     dec_diff;
  logic [NIBBLES:0] nib_carry;
  logic             bin_carry;
  sbc_flags_t       nx_flags;
  logic [W-1:0]     nx_diff;

  sbc_bin_chain #(.NIBBLES(NIBBLES)) i_chain (
    .a(acc), .m(opnd), .cin(carry_in), .d(bin_diff), .nib_carry(nib_carry)
  );

  sbc_dec_adjust #(.NIBBLES(NIBBLES)) i_adj (
    .bin_d(bin_diff), .nib_carry(nib_carry), .dec_d(dec_diff)
  );

  assign bin_carry = nib_carry[NIBBLES];

  sbc_flag_gen #(.W(W)) i_flags (
    .a(acc[W-1]), .m(opnd[W-1]), .r(bin_diff), .carry(bin_carry), .flags(nx_flags)
  );

  assign nx_diff = dec_mode ? dec_diff : bin_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff      <= '0;
      carry_out <= 1'b0;
      zero      <= 1'b0;
      negative  <= 1'b0;
      overflow  <= 1'b0;
    end else if (en) begin
      diff      <= nx_diff;
      carry_out <= nx_flags.carry;
      zero      <= nx_flags.zero;
      negative  <= nx_flags.neg;
      overflow  <= nx_flags.ovf;
    end
  end
endmodule

// File: rtl/sbc_unit_chk.sv
module sbc_unit_chk #(
  parameter int NIBBLES = 2,
  localparam int W = 4 * NIBBLES
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         dec_mode,
  input logic         carry_in,
  input logic [W-1:0] acc,
  input logic [W-1:0] opnd,
  input logic [W-1:0] diff,
  input logic         carry_out,
  input logic         zero,
  input logic         negative,
  input logic         bin_carry
);
  a_r2_carry_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dec_mode) |=> carry_out ==
      ({1'b0, $past(acc)} >= ({1'b0, $past(opnd)} + {{W{1'b0}}, !$past(carry_in)})));

  a_r3_neg_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dec_mode) |=> negative == diff[W-1]);

  a_r4_zero_all: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dec_mode) |=> zero == (diff == '0));

  a_r7_dec_carry: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> carry_out == $past(bin_carry));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(diff) && $stable(carry_out) && $stable(zero)));
endmodule

bind sbc_unit sbc_unit_chk #(.NIBBLES(NIBBLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dec_mode(dec_mode), .carry_in(carry_in),
  .acc(acc), .opnd(opnd), .diff(diff), .carry_out(carry_out), .zero(zero),
  .negative(negative), .bin_carry(bin_carry)
);

// File: tb/test_sbc_unit.sv
module test_sbc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       dec_mode = 1'b0;
  logic       carry_in = 1'b0;
  logic [7:0] acc = '0;
  logic [7:0] opnd = '0;
  logic [7:0] diff;
  logic       carry_out, zero, negative, overflow;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sbc_unit #(.NIBBLES(2)) i_sbc_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .dec_mode(dec_mode), .carry_in(carry_in),
    .acc(acc), .opnd(opnd), .diff(diff), .carry_out(carry_out), .zero(zero),
    .negative(negative), .overflow(overflow)
  );

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] m, input logic c,
                       input logic d);
    @(negedge clk);
    acc = a; opnd = m; carry_in = c; dec_mode = d; en = 1'b1;
    @(posedge clk);
    #1;
  endtask

  // binary reference: R1..R5
  task automatic check_bin(input logic [7:0] a, input logic [7:0] m, input logic c);
    int ud, sd;
    logic [7:0] er;
    logic ec, ez, en_, ev;
    bit bad = 0;
    ud  = int'(a) - int'(m) - (c ? 0 : 1);
    sd  = int'($signed(a)) - int'($signed(m)) - (c ? 0 : 1);
    er  = 8'(ud);
    ec  = (ud >= 0);
    ez  = (er == 8'h00);
    en_ = er[7];
    ev  = (sd < -128) || (sd > 127);
    vectors++;
    if (diff !== er) begin bad = 1; $display("FAIL R1 a=%h m=%h c=%b diff=%h exp=%h", a, m, c, diff, er); end
    if (carry_out !== ec) begin bad = 1; $display("FAIL R2 a=%h m=%h c=%b carry=%b exp=%b", a, m, c, carry_out, ec); end
    if (negative !== en_) begin bad = 1; $display("FAIL R3 a=%h m=%h c=%b neg=%b exp=%b", a, m, c, negative, en_); end
    if (zero !== ez) begin bad = 1; $display("FAIL R4 a=%h m=%h c=%b zero=%b exp=%b", a, m, c, zero, ez); end
    if (overflow !== ev) begin bad = 1; $display("FAIL R5 a=%h m=%h c=%b ovf=%b exp=%b", a, m, c, overflow, ev); end
    if (bad) misses++;
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // decimal reference: R6, R7
  task automatic check_dec(input int x, input int y, input logic c);
    int dv;
    logic [7:0] er;
    logic ec;
    bit bad = 0;
    dv = x - y - (c ? 0 : 1);
    ec = (dv >= 0);
    er = to_bcd(dv < 0 ? dv + 100 : dv);
    vectors++;
    if (diff !== er) begin bad = 1; $display("FAIL R6 x=%0d y=%0d c=%b diff=%h exp=%h", x, y, c, diff, er); end
    if (carry_out !== ec) begin bad = 1; $display("FAIL R7 x=%0d y=%0d c=%b carry=%b exp=%b", x, y, c, carry_out, ec); end
    if (bad) misses++;
  endtask

  // R8: two-byte chained subtraction
  task automatic chain16(input logic [15:0] a, input logic [15:0] m);
    logic [7:0] lo;
    int ud, sd;
    logic [15:0] er;
    logic ec, ev;
    bit bad = 0;
    drive(a[7:0], m[7:0], 1'b1, 1'b0);
    lo = diff;
    drive(a[15:8], m[15:8], carry_out, 1'b0);
    ud = int'(a) - int'(m);
    sd = int'($signed(a)) - int'($signed(m));
    er = 16'(ud);
    ec = (ud >= 0);
    ev = (sd < -32768) || (sd > 32767);
    vectors++;
    if ({diff, lo} !== er) begin bad = 1; $display("FAIL R8 a=%h m=%h diff=%h exp=%h", a, m, {diff, lo}, er); end
    if (carry_out !== ec) begin bad = 1; $display("FAIL R8 a=%h m=%h carry=%b exp=%b", a, m, carry_out, ec); end
    if (overflow !== ev) begin bad = 1; $display("FAIL R8 a=%h m=%h ovf=%b exp=%b", a, m, overflow, ev); end
    if (bad) misses++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [7:0] held;
    logic hc;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    vectors++;
    if ({diff, carry_out, zero, negative, overflow} !== 12'h000) begin
      misses++;
      $display("FAIL R10 outputs=%h exp=000", {diff, carry_out, zero, negative, overflow});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1-R5 exhaustive binary sweep
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int m = 0; m < 256; m++) begin
          drive(8'(a), 8'(m), c[0], 1'b0);
          check_bin(8'(a), 8'(m), c[0]);
        end

    // R6, R7: every valid BCD pair
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 100; x++)
        for (int y = 0; y < 100; y++) begin
          drive(to_bcd(x), to_bcd(y), c[0], 1'b1);
          check_dec(x, y, c[0]);
        end

    // R8: chained two-byte cases
    chain16(16'h1234, 16'h0FFF);
    chain16(16'h0000, 16'h0001);
    chain16(16'h8000, 16'h0001);
    chain16(16'h7FFF, 16'hFFFF);
    chain16(16'hFFFF, 16'hFFFF);

    // R9: hold when en is low
    drive(8'h50, 8'h20, 1'b1, 1'b0);
    held = diff;
    hc = carry_out;
    @(negedge clk);
    en = 1'b0; acc = 8'h00; opnd = 8'h01; carry_in = 1'b0;
    @(posedge clk);
    #1;
    vectors++;
    if (diff !== held || carry_out !== hc) begin
      misses++;
      $display("FAIL R9 diff=%h carry=%b exp=%h %b", diff, carry_out, held, hc);
    end

    done = 1;
    report();
  end
endmodule